// File: doc/BRIEF.md
# Multi-Mode Programmable Down-Counter Channel

This block is one channel of an interval timer. A host-side register block hands it two single-cycle pulses: one that selects an operating behaviour and one that delivers a new 16-bit initial count N. The channel then counts down on the clock and drives one output line. A gate input enables counting, or starts it. The running count is brought out so that the host side can latch it. Counting is plain binary and always downward; the step from 1 to 0 is the terminal count.

Six behaviours share the one down-counter. In mode 0 the output rises at terminal count and can serve as an interrupt request. Mode 1 is a one-shot that the gate can retrigger. Mode 2 divides the clock by N and gives a single-cycle low pulse. Mode 3 gives a square wave. Mode 4 is a strobe that starts when the count is written. Mode 5 is a strobe that starts on a gate edge. Modes 2 and 3 reload by themselves. Modes 1 and 5 react to a rising gate edge and ignore the gate level while they count.

Top module: `tmr_chan`

## Requirements
- R1: After reset the output is low, the visible count is 0 and the channel is in mode 0.
- R2: Mode 0 (mode_in = 0): a count write drives the output low, and the output rises after the (N+1)-th clock edge counted from the write edge. Afterwards the counter keeps decrementing and wraps from 0 to 0xFFFF, while the output stays high.
- R3: Mode 1 (mode_in = 1): once a count has been written, a rising gate edge drives the output low at that edge, and the output returns high N edges later. A new rising edge during the low phase reloads N and restarts the low time.
- R4: Mode 2 (mode_in = 2): with the gate high, the output is low for exactly one clock once the count reaches 1, and the count then reloads N. The period is N clocks, and the first low pulse follows the N-th edge after the write edge.
- R5: Mode 3 (mode_in = 3): the output repeats with a period of N clocks. It is high for ceil(N/2) clocks and low for floor(N/2) clocks, and it goes high again at each reload.
- R6: Mode 4 (mode_in = 4): with the gate high, the output pulses low for one clock after the (N+1)-th edge from the write edge. There is no further pulse until the count is written again, even after the counter wraps.
- R7: Mode 5 (mode_in = 5): a rising gate edge loads N, and the output pulses low for one clock after the N-th following edge. A rising gate edge before any count has been written has no effect.
- R8: A low gate holds the count in modes 0, 2, 3 and 4. In modes 2 and 3 a low gate also forces the output high one edge later, and the next rising gate edge reloads N.
- R9: A mode write sets the output to its idle level one edge later: low for mode 0 and high for the other modes. The count then stays frozen until a new count is written.
- R10: A written count of 0 behaves as 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | One-cycle pulse: take mode_in as the new mode |
| mode_in | input | 3 | Mode code 0..5 (6 and 7 act as 2 and 3) |
| cnt_wr | input | 1 | One-cycle pulse: take cnt_in as the new initial count |
| cnt_in | input | CNT_W | Initial count N |
| gate | input | 1 | Gate level, sampled on clk |
| out_o | output | 1 | Channel output |
| count_o | output | CNT_W | Current counter value, for latching |

## Verification
Three situations are hard to reach from the ports. A count of 0 has to be shown to mean 65536. The mode 4 strobe must not repeat after a full wrap. The channel must wait for the gate after the gate has cut a square or rate wave in mid-period. The bench covers the first two by letting the counter run through 65536 edges, once in mode 0 and once in mode 4 after its strobe, and by counting low samples over the whole wrap. For the third, it drops the gate on the very sample where the rate output is low, checks that the output is forced high and that the count holds, and then raises the gate to see the reload value appear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    M_IRQ     = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } tmr_mode_e;

  // codes 6 and 7 fold onto the two periodic modes
  function automatic tmr_mode_e norm_mode(input logic [2:0] m);
    if (m == 3'd6)      return M_RATE;
    else if (m == 3'd7) return M_SQUARE;
    else                return tmr_mode_e'(m);
  endfunction

  function automatic logic is_periodic(input tmr_mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

  function automatic logic is_gate_trig(input tmr_mode_e m);
    return (m == M_ONESHOT) || (m == M_HWSTB);
  endfunction

  function automatic logic restarts_on_write(input tmr_mode_e m);
    return (m == M_IRQ) || (m == M_SWSTB);
  endfunction

  function automatic logic idle_level(input tmr_mode_e m);
    return (m != M_IRQ);
  endfunction

endpackage

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic gate_rise
);
  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign gate_rise = gate & ~gate_q;
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_wr,
  input  logic [2:0]     mode_in,
  input  logic           cnt_wr,
  input  logic [W-1:0]   cnt_in,
  input  logic           gate,
  input  logic           gate_rise,
  input  logic           tc_ev,
  output tmr_mode_e      mode_q,
  output logic [W-1:0]   init_q,
  output logic           fired_q,
  output logic           load_ev,
  output logic           dec_ev
);
  logic armed_q, run_q, pend_q;
  logic trig_hw, trig_per;

  assign trig_hw  = gate_rise & armed_q & is_gate_trig(mode_q);
  assign trig_per = gate_rise & run_q & is_periodic(mode_q);
  assign load_ev  = ~mode_wr & (pend_q | trig_hw | trig_per);
  assign dec_ev   = ~mode_wr & ~load_ev & run_q & (gate | is_gate_trig(mode_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_IRQ;
      init_q  <= '0;
      armed_q <= 1'b0;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      fired_q <= 1'b0;
    end else if (mode_wr) begin
      mode_q  <= norm_mode(mode_in);
      armed_q <= 1'b0;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      if (load_ev) begin
        run_q   <= 1'b1;
        pend_q  <= 1'b0;
        fired_q <= 1'b0;
      end else if (tc_ev) begin
        fired_q <= 1'b1;
      end
      if (cnt_wr) begin
        init_q  <= cnt_in;
        armed_q <= 1'b1;
        if (restarts_on_write(mode_q)) begin
          pend_q <= 1'b1;
          run_q  <= 1'b0;
        end else if (is_periodic(mode_q) && !run_q) begin
          pend_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_ev,
  input  logic         dec_ev,
  input  logic         periodic,
  input  logic         square,
  input  logic [W-1:0] init,
  output logic [W-1:0] cnt_q,
  output logic         tc_ev,
  output logic         mark_ev
);
  localparam int EW = W + 1;

  // a written zero stands for the full range 2**W
  function automatic logic [EW-1:0] eff_len(input logic [W-1:0] n);
    return (n == '0) ? {1'b1, {W{1'b0}}} : {1'b0, n};
  endfunction

  // counter value the output falls at (after the decrement)
  function automatic logic [EW-1:0] low_mark(input logic [W-1:0] n, input logic sq);
    return sq ? (eff_len(n) >> 1) : EW'(1);
  endfunction

  logic at_one;
  assign at_one  = (cnt_q == W'(1));
  assign tc_ev   = dec_ev & at_one;
  assign mark_ev = dec_ev & periodic & ({1'b0, cnt_q} == low_mark(init, square) + EW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load_ev)              cnt_q <= init;
    else if (dec_ev) begin
      if (at_one && periodic)      cnt_q <= init;
      else                         cnt_q <= cnt_q - W'(1);
    end
  end
endmodule

// File: rtl/tmr_out_ctl.sv
module tmr_out_ctl
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [2:0] mode_in,
  input  logic       cnt_wr,
  input  tmr_mode_e  mode_q,
  input  logic       gate,
  input  logic       load_ev,
  input  logic       tc_ev,
  input  logic       mark_ev,
  input  logic       fired,
  output logic       out_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
    end else if (mode_wr) begin
      out_q <= idle_level(norm_mode(mode_in));
    end else begin
      unique case (mode_q)
        M_IRQ: begin
          if (cnt_wr)     out_q <= 1'b0;
          else if (tc_ev) out_q <= 1'b1;
        end
        M_ONESHOT: begin
          if (load_ev)    out_q <= 1'b0;
          else if (tc_ev) out_q <= 1'b1;
        end
        M_RATE, M_SQUARE: begin
          if (!gate || load_ev || tc_ev) out_q <= 1'b1;
          else if (mark_ev)              out_q <= 1'b0;
        end
        default: begin
          if (!out_q)                out_q <= 1'b1;
          else if (tc_ev && !fired)  out_q <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [2:0]       mode_in,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             gate,
  output logic             out_o,
  output logic [CNT_W-1:0] count_o
);
  tmr_mode_e        mode_q;
  logic [2:0]       mode_code;
  logic [CNT_W-1:0] init_q;
  logic             gate_rise, load_ev, dec_ev, tc_ev, mark_ev, fired_q;

  assign mode_code = mode_q;

  tmr_gate_edge u_gate (
    .clk(clk), .rst_n(rst_n), .gate(gate), .gate_rise(gate_rise)
  );

  tmr_ctrl #(.W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
    .cnt_wr(cnt_wr), .cnt_in(cnt_in), .gate(gate), .gate_rise(gate_rise),
    .tc_ev(tc_ev), .mode_q(mode_q), .init_q(init_q), .fired_q(fired_q),
    .load_ev(load_ev), .dec_ev(dec_ev)
  );

  tmr_count_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .load_ev(load_ev), .dec_ev(dec_ev),
    .periodic(is_periodic(mode_q)), .square(mode_q == M_SQUARE),
    .init(init_q), .cnt_q(count_o), .tc_ev(tc_ev), .mark_ev(mark_ev)
  );

  tmr_out_ctl u_out (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
    .cnt_wr(cnt_wr), .mode_q(mode_q), .gate(gate), .load_ev(load_ev),
    .tc_ev(tc_ev), .mark_ev(mark_ev), .fired(fired_q), .out_q(out_o)
  );
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode_wr,
  input logic [2:0]   mode_in,
  input logic         gate,
  input logic         out_o,
  input logic [W-1:0] count_o,
  input logic [2:0]   mode_code,
  input logic         load_ev,
  input logic         tc_ev
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !$past(rst_n)) |-> (!out_o && count_o == '0));

  a_r2_tc_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd0 && tc_ev && !mode_wr) |=> out_o);

  a_r3_trigger_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd1 && load_ev && !mode_wr) |=> !out_o);

  a_r4_single_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd2 && !out_o && !mode_wr) |=> out_o);

  a_r6_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_code == 3'd4 || mode_code == 3'd5) && !out_o && !mode_wr) |=> out_o);

  a_r8_gate_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_code == 3'd2 || mode_code == 3'd3) && !gate && !mode_wr) |=> out_o);

  a_r8_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_code == 3'd0 || mode_code == 3'd2 || mode_code == 3'd3 || mode_code == 3'd4)
     && !gate && !load_ev && !mode_wr) |=> $stable(count_o));

  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_in == 3'd0) |=> !out_o);

  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_in != 3'd0) |=> out_o);

  a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> $stable(count_o));
endmodule

bind tmr_chan tmr_chan_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
  .gate(gate), .out_o(out_o), .count_o(count_o), .mode_code(mode_code),
  .load_ev(load_ev), .tc_ev(tc_ev)
);

// File: tb/tmr_chan_tb.sv
module tmr_chan_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_wr = 1'b0;
  logic [2:0]   mode_in = 3'd0;
  logic         cnt_wr = 1'b0;
  logic [W-1:0] cnt_in = '0;
  logic         gate = 1'b0;
  logic         out_o;
  logic [W-1:0] count_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_chan #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
    .cnt_wr(cnt_wr), .cnt_in(cnt_in), .gate(gate),
    .out_o(out_o), .count_o(count_o)
  );

  // mode, count, edges to first change, to second, to third (0: not checked)
  typedef struct packed {
    logic [2:0]  m;
    logic [15:0] n;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [7:0]  c;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 16'd5, 8'd6, 8'd0, 8'd0},
    '{3'd0, 16'd1, 8'd2, 8'd0, 8'd0},
    '{3'd1, 16'd4, 8'd0, 8'd4, 8'd0},
    '{3'd1, 16'd1, 8'd0, 8'd1, 8'd0},
    '{3'd2, 16'd3, 8'd3, 8'd1, 8'd2},
    '{3'd2, 16'd6, 8'd6, 8'd1, 8'd5},
    '{3'd3, 16'd4, 8'd3, 8'd2, 8'd2},
    '{3'd3, 16'd5, 8'd4, 8'd2, 8'd3},
    '{3'd3, 16'd3, 8'd3, 8'd1, 8'd2},
    '{3'd4, 16'd3, 8'd4, 8'd1, 8'd0},
    '{3'd5, 16'd2, 8'd2, 8'd1, 8'd0},
    '{3'd5, 16'd7, 8'd7, 8'd1, 8'd0}
  };

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(input logic [2:0] m);
    mode_wr = 1'b1; mode_in = m;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic wr_cnt(input logic [W-1:0] n);
    cnt_wr = 1'b1; cnt_in = n;
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  // number of edges until out_o differs from its level at the call
  task automatic edges_to_change(output int n);
    logic lvl;
    lvl = out_o;
    n = 0;
    forever begin
      @(negedge clk);
      cnt_wr = 1'b0;
      n++;
      if (out_o != lvl || n > 70000) break;
    end
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    string tags [6] = '{"R2", "R3", "R4", "R5", "R6", "R7"};
    int n1, n2, n3, lows;
    logic [W-1:0] held;

    step(3);
    chk("R1 out after reset", out_o, 0);
    chk("R1 count after reset", count_o, 0);
    rst_n = 1'b1;
    step(2);
    chk("R1 out stays low in mode 0", out_o, 0);

    for (int i = 0; i < NV; i++) begin
      logic hw;
      hw = (VECS[i].m == 3'd1) || (VECS[i].m == 3'd5);
      gate = ~hw;
      wr_mode(VECS[i].m);
      step(1);
      if (hw) begin
        wr_cnt(VECS[i].n);
        step(2);
        gate = 1'b1;
      end else begin
        cnt_wr = 1'b1; cnt_in = VECS[i].n;
      end
      edges_to_change(n1);
      chk({tags[VECS[i].m], " first change"}, n1 - 1, VECS[i].a);
      if (VECS[i].m == 3'd0) begin
        step(1);
        chk("R2 wrap after terminal count", count_o, 16'hFFFF);
        chk("R2 out held high after wrap", out_o, 1);
      end else begin
        edges_to_change(n2);
        chk({tags[VECS[i].m], " second change"}, n2, VECS[i].b);
        if (VECS[i].c != 0) begin
          edges_to_change(n3);
          chk({tags[VECS[i].m], " next period change"}, n3, VECS[i].c);
        end
      end
    end

    // R8: gate low holds a mode 0 count
    gate = 1'b0;
    wr_mode(3'd0);
    wr_cnt(16'd4);
    step(5);
    chk("R8 count held with gate low", count_o, 4);
    chk("R8 out low while held", out_o, 0);
    gate = 1'b1;
    edges_to_change(n1);
    chk("R8 count resumes after gate high", n1, 4);

    // R8: gate low mid-period in mode 2
    wr_mode(3'd2);
    cnt_wr = 1'b1; cnt_in = 16'd3;
    edges_to_change(n1);
    chk("R8 rate low pulse reached", out_o, 0);
    gate = 1'b0;
    step(1);
    chk("R8 gate low forces high", out_o, 1);
    held = count_o;
    step(3);
    chk("R8 count frozen by gate", count_o, held);
    gate = 1'b1;
    step(1);
    chk("R8 gate rise reloads", count_o, 3);

    // R9: mode write sets idle level and freezes the count
    step(1);
    wr_mode(3'd0);
    chk("R9 mode 0 idle low", out_o, 0);
    held = count_o;
    step(3);
    chk("R9 count frozen after mode write", count_o, held);
    wr_mode(3'd4);
    chk("R9 mode 4 idle high", out_o, 1);

    // R3: retrigger restarts the one-shot
    gate = 1'b0;
    wr_mode(3'd1);
    wr_cnt(16'd4);
    step(2);
    gate = 1'b1;
    step(1);
    chk("R3 one-shot low at trigger", out_o, 0);
    step(1);
    gate = 1'b0;
    step(1);
    gate = 1'b1;
    step(1);
    chk("R3 retrigger reloads count", count_o, 4);
    chk("R3 out still low on retrigger", out_o, 0);
    edges_to_change(n1);
    chk("R3 low time restarted", n1, 4);

    // R7: gate edge without a written count is ignored
    gate = 1'b0;
    wr_mode(3'd5);
    held = count_o;
    step(1);
    gate = 1'b1;
    lows = 0;
    for (int k = 0; k < 10; k++) begin
      step(1);
      if (!out_o) lows++;
    end
    chk("R7 unarmed trigger no strobe", lows, 0);
    chk("R7 unarmed trigger count unchanged", count_o, held);

    // R10: count of 0 in mode 0 means 65536
    wr_mode(3'd0);
    cnt_wr = 1'b1; cnt_in = '0;
    edges_to_change(n1);
    chk("R10 zero count gives 65536", n1 - 1, 65537);

    // R6: mode 4 strobes once, not again after a full wrap
    wr_mode(3'd4);
    cnt_wr = 1'b1; cnt_in = 16'd2;
    edges_to_change(n1);
    chk("R6 strobe delay", n1 - 1, 3);
    edges_to_change(n2);
    chk("R6 strobe width", n2, 1);
    lows = 0;
    for (int k = 0; k < 65540; k++) begin
      step(1);
      if (!out_o) lows++;
    end
    chk("R6 no repeat after wrap", lows, 0);

    done = 1'b1;
    report();
  end
endmodule